// File: doc/BRIEF.md
# Split-Screen Display Address Generator

This block produces the display memory address for a CRT-style video controller. It holds a row start address and a running character address. Each character clock strobe steps the running address by one. At the end of every scan line the running address goes back to the row start, so all scan lines of a character row fetch the same memory. After the last scan line of a row, the row start moves forward by a programmable offset.

The block counts scan lines from the frame strobe and compares the count with a 10-bit split target. The target is built from an 8-bit low part and two separate high bits. When the line that is starting matches the target, both the running address and the row start restart at zero. This lets the lower part of the screen show memory from address 0 onward, independent of the programmed start address.

The logical address is then mapped to a physical address. Byte mode passes it through unchanged. Word mode and doubleword mode shift it left and fill the low bits from selected high bits. The result drives memory directly.

Top module: `split_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, mem_addr is 0 when byte mode (mode 0) is selected.
- R2: A frame_start strobe loads start_addr into both the running address and the row start, and restarts the scan-line and row-scan counters at 0.
- R3: A char_adv strobe, with no frame_start or line_end in the same cycle, increments the running address by 1. With no strobe, the address holds.
- R4: A line_end that does not end the character row and does not hit the split target sets the running address back to the current row start.
- R5: A line_end on the last scan line of a row (row-scan count equal to max_scan) adds row_offset to the row start, and the running address takes the new row start.
- R6: The split target is {cmp_hi9, cmp_hi8, cmp_lo}. When a line_end starts a line whose number (counted from 0 at frame_start) equals the target, the running address and the row start become 0. The following rows advance by row_offset from 0.
- R7: With dbl_scan set, each row spans 2*(max_scan+1) lines. The split compare still uses the raw line count.
- R8: frame_start has priority over a split hit, and a split hit has priority over a row advance. A line_end has priority over char_adv.
- R9: Mode 0 (byte): mem_addr equals the logical address.
- R10: Mode 1 (word): mem_addr[15:1] = logical[14:0]. mem_addr[0] = logical[13] when wrap_sel is 0, and logical[15] when wrap_sel is 1.
- R11: Mode 2 or 3 (doubleword): mem_addr[15:2] = logical[13:0]. mem_addr[0] = logical[12] ^ (logical[14] & xor_en). mem_addr[1] = logical[13] ^ (logical[15] & xor_en).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame strobe (vertical sync) |
| line_end | input | 1 | End-of-scan-line strobe (horizontal sync) |
| char_adv | input | 1 | Character fetch strobe |
| start_addr | input | 16 | Programmed frame start address |
| row_offset | input | 16 | Row-to-row address increment |
| max_scan | input | 5 | Index of the last scan line in a character row |
| dbl_scan | input | 1 | Double-scan enable |
| cmp_lo | input | 8 | Split target bits 7:0 |
| cmp_hi8 | input | 1 | Split target bit 8 |
| cmp_hi9 | input | 1 | Split target bit 9 |
| mode | input | 2 | Address mode: 0 byte, 1 word, 2 or 3 doubleword |
| wrap_sel | input | 1 | Word mode: source bit for physical bit 0 |
| xor_en | input | 1 | Doubleword mode: enables the XOR terms |
| mem_addr | output | 16 | Physical display memory address |

## Verification
A corrupted row start shows up only at the next line_end, when the address falls back to the wrong base. A corrupted running address is visible on mem_addr in the same cycle. A wrong scan-line or row-scan count is silent until the split line or the row boundary is reached. The corner tests therefore run hundreds of lines to reach the split targets that use bit 8 and bit 9. They also check the address on the line just before each boundary, so an early hit is detected as well.

// File: rtl/sa_pkg.sv
package sa_pkg;
    typedef enum logic [1:0] {
        AM_BYTE  = 2'd0,
        AM_WORD  = 2'd1,
        AM_DWORD = 2'd2,
        AM_DWRD2 = 2'd3
    } amode_e;
endpackage

// File: rtl/sa_line_counter.sv
module sa_line_counter #(
    parameter int LINE_W = 10,
    parameter int ROW_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_end,
    input  logic              dbl_scan,
    input  logic [ROW_W-1:0]  max_scan,
    input  logic [LINE_W-1:0] line_cmp,
    output logic              split_hit,
    output logic              row_done
);
    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [ROW_W-1:0]  rscan;
        logic              phase;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [LINE_W-1:0] next_line;

    always_comb begin
        next_line = cnt_q.line + 1'b1;
        split_hit = line_end && (next_line == line_cmp);
        row_done  = line_end && (cnt_q.rscan == max_scan) && (!dbl_scan || cnt_q.phase);
        cnt_d = cnt_q;
        if (frame_start) begin
            cnt_d = '0;
        end else if (line_end) begin
            cnt_d.line = next_line;
            if (split_hit || row_done) begin
                cnt_d.rscan = '0;
                cnt_d.phase = 1'b0;
            end else if (dbl_scan) begin
                cnt_d.phase = ~cnt_q.phase;
                if (cnt_q.phase) cnt_d.rscan = cnt_q.rscan + 1'b1;
            end else begin
                cnt_d.rscan = cnt_q.rscan + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sa_addr_map.sv
module sa_addr_map
    import sa_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] log_addr,
    input  logic [1:0]        mode,
    input  logic              wrap_sel,
    input  logic              xor_en,
    output logic [ADDR_W-1:0] phys_addr
);
    localparam int TOP = ADDR_W - 1;

    logic w_bit0, d_bit0, d_bit1;

    always_comb begin
        w_bit0 = wrap_sel ? log_addr[TOP] : log_addr[TOP-2];
        d_bit0 = log_addr[TOP-3] ^ (log_addr[TOP-1] & xor_en);
        d_bit1 = log_addr[TOP-2] ^ (log_addr[TOP] & xor_en);
        case (amode_e'(mode))
            AM_BYTE: phys_addr = log_addr;
            AM_WORD: phys_addr = {log_addr[TOP-1:0], w_bit0};
            default: phys_addr = {log_addr[TOP-2:0], d_bit1, d_bit0};
        endcase
    end
endmodule

// File: rtl/split_addr_gen.sv
module split_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int ROW_W  = 5,
    parameter int CMP_LO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_end,
    input  logic              char_adv,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] row_offset,
    input  logic [ROW_W-1:0]  max_scan,
    input  logic              dbl_scan,
    input  logic [CMP_LO-1:0] cmp_lo,
    input  logic              cmp_hi8,
    input  logic              cmp_hi9,
    input  logic [1:0]        mode,
    input  logic              wrap_sel,
    input  logic              xor_en,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int LINE_W = CMP_LO + 2;

    typedef struct packed {
        logic [ADDR_W-1:0] row_base;
        logic [ADDR_W-1:0] addr;
    } ast_t;

    ast_t st_d, st_q;
    logic [LINE_W-1:0] line_cmp;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] next_base;
    logic              split_hit;
    logic              row_done;

    assign line_cmp = {cmp_hi9, cmp_hi8, cmp_lo};
    assign addr_q   = st_q.addr;

    sa_line_counter #(.LINE_W(LINE_W), .ROW_W(ROW_W)) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_end    (line_end),
        .dbl_scan    (dbl_scan),
        .max_scan    (max_scan),
        .line_cmp    (line_cmp),
        .split_hit   (split_hit),
        .row_done    (row_done)
    );

    always_comb begin
        next_base = st_q.row_base + row_offset;
        st_d = st_q;
        if (frame_start) begin
            st_d.row_base = start_addr;
            st_d.addr     = start_addr;
        end else if (line_end) begin
            if (split_hit) begin
                st_d.row_base = '0;
                st_d.addr     = '0;
            end else if (row_done) begin
                st_d.row_base = next_base;
                st_d.addr     = next_base;
            end else begin
                st_d.addr     = st_q.row_base;
            end
        end else if (char_adv) begin
            st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sa_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .log_addr  (st_q.addr),
        .mode      (mode),
        .wrap_sel  (wrap_sel),
        .xor_en    (xor_en),
        .phys_addr (mem_addr)
    );
endmodule

// File: rtl/sa_chk.sv
module sa_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              line_end,
    input logic              char_adv,
    input logic              split_hit,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] addr_q,
    input logic [1:0]        mode,
    input logic [ADDR_W-1:0] mem_addr
);
    // R2
    frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> addr_q == $past(start_addr));

    // R6
    split_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split_hit && !frame_start) |=> addr_q == '0);

    // R3
    char_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_adv && !frame_start && !line_end) |=> addr_q == $past(addr_q) + 1'b1);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_adv && !frame_start && !line_end) |=> $stable(addr_q));

    // R9
    byte_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> mem_addr == addr_q);
endmodule

bind split_addr_gen sa_chk #(.ADDR_W(ADDR_W)) u_sa_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_end    (line_end),
    .char_adv    (char_adv),
    .split_hit   (split_hit),
    .start_addr  (start_addr),
    .addr_q      (addr_q),
    .mode        (mode),
    .mem_addr    (mem_addr)
);

// File: tb/tb_split_addr_gen.sv
`timescale 1ns/1ps
module tb_split_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, line_end = 1'b0, char_adv = 1'b0;
    logic [15:0] start_addr = '0, row_offset = '0;
    logic [4:0]  max_scan = '0;
    logic        dbl_scan = 1'b0;
    logic [7:0]  cmp_lo = 8'hFF;
    logic        cmp_hi8 = 1'b1, cmp_hi9 = 1'b1;
    logic [1:0]  mode = '0;
    logic        wrap_sel = 1'b0, xor_en = 1'b0;
    logic [15:0] mem_addr;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    split_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_end(line_end),
        .char_adv(char_adv), .start_addr(start_addr), .row_offset(row_offset),
        .max_scan(max_scan), .dbl_scan(dbl_scan), .cmp_lo(cmp_lo), .cmp_hi8(cmp_hi8),
        .cmp_hi9(cmp_hi9), .mode(mode), .wrap_sel(wrap_sel), .xor_en(xor_en),
        .mem_addr(mem_addr)
    );

    // {mode, wrap_sel, xor_en, logical, expected physical}
    typedef struct packed {
        logic [1:0]  md;
        logic        ws;
        logic        xe;
        logic [15:0] la;
        logic [15:0] pa;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b0, 1'b0, 16'hA5C3, 16'hA5C3},   // R9
        '{2'd1, 1'b0, 1'b0, 16'h2001, 16'h4003},   // R10 bit0 from 13
        '{2'd1, 1'b1, 1'b0, 16'h2001, 16'h4002},   // R10 bit0 from 15
        '{2'd1, 1'b1, 1'b0, 16'h8000, 16'h0001},   // R10
        '{2'd2, 1'b0, 1'b0, 16'hF003, 16'hC00F},   // R11 xor off
        '{2'd2, 1'b0, 1'b1, 16'hF003, 16'hC00C},   // R11 xor on
        '{2'd2, 1'b0, 1'b1, 16'h4000, 16'h0001},   // R11
        '{2'd3, 1'b0, 1'b1, 16'h8000, 16'h0002}    // R11 mode 3
    };

    task automatic check(input string req, input logic [15:0] exp);
        n_run++;
        if (mem_addr !== exp) begin
            n_fail++;
            $display("FAIL %s: mem_addr=%h expected=%h", req, mem_addr, exp);
        end
    endtask

    task automatic strobe(input logic f, input logic le, input logic ca);
        @(negedge clk);
        frame_start = f; line_end = le; char_adv = ca;
        @(negedge clk);
        frame_start = 1'b0; line_end = 1'b0; char_adv = 1'b0;
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) strobe(1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 16'h0000);

        foreach (VECS[i]) begin
            mode = VECS[i].md; wrap_sel = VECS[i].ws; xor_en = VECS[i].xe;
            start_addr = VECS[i].la;
            strobe(1'b1, 1'b0, 1'b0);
            check("R9/R10/R11 map", VECS[i].pa);
        end
        mode = 2'd0; wrap_sel = 1'b0; xor_en = 1'b0;

        // R2, R3, R4, R5
        start_addr = 16'h0100; row_offset = 16'h0028; max_scan = 5'd1;
        strobe(1'b1, 1'b0, 1'b0);
        check("R2", 16'h0100);
        strobe(1'b0, 1'b0, 1'b1); strobe(1'b0, 1'b0, 1'b1); strobe(1'b0, 1'b0, 1'b1);
        check("R3", 16'h0103);
        repeat (4) @(negedge clk);
        check("R3 hold", 16'h0103);
        lines(1);
        check("R4", 16'h0100);
        strobe(1'b0, 1'b0, 1'b1);
        lines(1);
        check("R5", 16'h0128);

        // R6 split at line 5, then rows advance from 0
        cmp_lo = 8'd5; cmp_hi8 = 1'b0; cmp_hi9 = 1'b0;
        strobe(1'b1, 1'b0, 1'b0);
        lines(4);
        check("R5 before split", 16'h0150);
        lines(1);
        check("R6", 16'h0000);
        strobe(1'b0, 1'b0, 1'b1); strobe(1'b0, 1'b0, 1'b1);
        check("R6 count", 16'h0002);
        lines(1);
        check("R6 restart", 16'h0000);
        lines(1);
        check("R6 advance", 16'h0028);

        // R6 bit 8 of target
        cmp_lo = 8'd5; cmp_hi8 = 1'b1;
        strobe(1'b1, 1'b0, 1'b0);
        lines(5);
        check("R6 hi8 no early", 16'h0150);
        lines(256);
        check("R6 hi8", 16'h0000);

        // R6 bit 9 of target
        cmp_lo = 8'd0; cmp_hi8 = 1'b0; cmp_hi9 = 1'b1;
        strobe(1'b1, 1'b0, 1'b0);
        lines(256);
        check("R6 hi9 no early", 16'h1500);
        lines(256);
        check("R6 hi9", 16'h0000);

        // R7 double scan
        cmp_lo = 8'hFF; cmp_hi8 = 1'b1; cmp_hi9 = 1'b1; dbl_scan = 1'b1;
        strobe(1'b1, 1'b0, 1'b0);
        lines(2);
        check("R7 row held", 16'h0100);
        lines(2);
        check("R7 row advance", 16'h0128);
        cmp_lo = 8'd3; cmp_hi8 = 1'b0; cmp_hi9 = 1'b0;
        strobe(1'b1, 1'b0, 1'b0);
        lines(2);
        check("R7 before split", 16'h0100);
        lines(1);
        check("R7 raw compare", 16'h0000);
        dbl_scan = 1'b0;

        // R8 priorities
        cmp_lo = 8'd1;
        strobe(1'b1, 1'b0, 1'b0);
        strobe(1'b1, 1'b1, 1'b0);
        check("R8 frame over split", 16'h0100);
        lines(1);
        check("R8 split follows", 16'h0000);
        cmp_lo = 8'd2;
        strobe(1'b1, 1'b0, 1'b0);
        lines(2);
        check("R8 split over advance", 16'h0000);
        cmp_lo = 8'hFF; cmp_hi8 = 1'b1; cmp_hi9 = 1'b1;
        strobe(1'b1, 1'b0, 1'b0);
        strobe(1'b0, 1'b0, 1'b1);
        strobe(1'b0, 1'b1, 1'b1);
        check("R8 line over char", 16'h0100);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule